// File: doc/BRIEF.md
# Watchdog with Fail-Safe Output Override

This block supervises a host by watching a heartbeat input for level changes. Once it is armed by a high wake input and the active-low reset is released, it counts ticks of a slow time base. Any change of heartbeat level restarts the count. If a full timeout period of ticks passes with no heartbeat change, the block enters fail-safe. In fail-safe it asserts a flag and forces two high-side channels on: channel 0 and channel 2. The flag and both forces are held until a re-initialise pulse or a reset arrives. After that, normal supervision resumes.

The timeout is a base period of `BASE_TICKS` ticks divided by 1, 2, 4 or 8. A two-bit divisor field selects the divider. The selected divider is only adopted when the host's watchdog bit changes level. Writing new divisor bits without toggling that bit leaves the running period as it was. Toggling the watchdog bit also restarts the count.

Top module: `wd_failsafe`

## Requirements
- R1: While `rstN` is low, `failSafe`, `forceHs0` and `forceHs2` are 0. The active divisor returns to 00, and the count and the edge history are cleared. Once `rstN` rises, the timeout starts from zero.
- R2: While `wakeIn` is 0, the count is held at zero and fail-safe is never entered.
- R3: With `wakeIn` high and the divisor at 00, `failSafe` rises at the edge that completes `BASE_TICKS` counted ticks with no restart. It is visible from the cycle after that tick.
- R4: A change of `wdIn` level in either direction restarts the count from zero.
- R5: `divSel` encodes the timeout as follows: 00 gives `BASE_TICKS`, 01 gives `BASE_TICKS`/2, 10 gives `BASE_TICKS`/4 and 11 gives `BASE_TICKS`/8. The value is adopted in the cycle where `wdBit` changes level.
- R6: Changing `divSel` while `wdBit` is steady has no effect on the running timeout.
- R7: A change of `wdBit` level restarts the count from zero.
- R8: While `failSafe` is 1, `forceHs0` and `forceHs2` are 1. `failSafe` stays 1, regardless of `wdIn` or `wdBit` activity, until `reinit` or reset.
- R9: A one-cycle `reinit` pulse clears `failSafe` on the next edge and restarts the count.
- R10: Ticks are counted only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset; holds the block in standby |
| tick | input | 1 | One-cycle time-base strobe |
| wakeIn | input | 1 | Arms the watchdog when high |
| wdIn | input | 1 | Heartbeat input; a level change restarts the count |
| divSel | input | 2 | Requested timeout divisor code |
| wdBit | input | 1 | Watchdog bit; a level change loads `divSel` and restarts the count |
| reinit | input | 1 | Re-initialise pulse; leaves fail-safe |
| failSafe | output | 1 | Fail-safe flag |
| forceHs0 | output | 1 | Force-on for high-side channel 0 |
| forceHs2 | output | 1 | Force-on for high-side channel 2 |

## Verification
The hardest case to reach is a staged divisor that must stay dormant. The divisor bits are rewritten while the watchdog bit is steady, and the run then has to show the old period still in force. Later, a toggle must adopt the new period and restart the count in the same cycle. The stimulus sets up this case by changing `divSel` alone and letting a full base period expire. It then toggles `wdBit` with the shortest divisor and times the trip to the exact cycle. Throughout, a behavioural model in the bench predicts all three outputs on every clock. This covers gated ticks, wake low, and heartbeat activity during fail-safe.

// File: rtl/wd_failsafe_pkg.sv
package wd_failsafe_pkg;

  typedef struct packed {
    logic clear;  // zero the tick counter
    logic step;   // advance the tick counter
    logic load;   // adopt the requested divisor
  } wdStrobes_t;

endpackage

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_failsafe_pkg::*;
#(
  parameter int BASE_TICKS = 64,
  parameter int DIV_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobes_t       strb,
  input  logic [DIV_W-1:0] divSel,
  output logic             atLast
);
  localparam int CNT_W    = $clog2(BASE_TICKS);
  localparam int NUM_DIVS = 1 << DIV_W;

  logic [DIV_W-1:0] activeDiv;
  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   limitTab [NUM_DIVS];
  logic [CNT_W:0]   limit;

  generate
    for (genvar d = 0; d < NUM_DIVS; d++) begin : g_limit
      localparam int LIM = ((BASE_TICKS >> d) < 1) ? 1 : (BASE_TICKS >> d);
      assign limitTab[d] = (CNT_W+1)'(LIM);
    end
  endgenerate

  assign limit  = limitTab[activeDiv];
  assign atLast = ({1'b0, count} == (limit - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          activeDiv <= '0;
    else if (strb.load) activeDiv <= divSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           count <= '0;
    else if (strb.clear) count <= '0;
    else if (strb.step)  count <= count + 1'b1;
  end

  // R4/R7: any restart leaves the counter at zero
  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0));

  // R3: the counter never reaches the active limit
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, count} < limit));

endmodule

// File: rtl/wd_ctrl.sv
module wd_ctrl
  import wd_failsafe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wakeIn,
  input  logic       wdIn,
  input  logic       wdBit,
  input  logic       reinit,
  input  logic       atLast,
  output wdStrobes_t strb,
  output logic       failSafe
);
  logic wdPrev, bitPrev;
  logic wdEdge, bitToggle, restart, advance, trip;

  assign wdEdge    = wdIn ^ wdPrev;
  assign bitToggle = wdBit ^ bitPrev;
  assign restart   = wdEdge | bitToggle | reinit | ~wakeIn;
  assign advance   = wakeIn & tick & ~failSafe & ~restart;
  assign trip      = advance & atLast;

  assign strb.clear = restart | trip;
  assign strb.step  = advance;
  assign strb.load  = bitToggle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdPrev  <= 1'b0;
      bitPrev <= 1'b0;
    end else begin
      wdPrev  <= wdIn;
      bitPrev <= wdBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       failSafe <= 1'b0;
    else if (reinit) failSafe <= 1'b0;
    else if (trip)   failSafe <= 1'b1;
  end

  // R2: never trips while disarmed
  p_wake_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wakeIn && !failSafe) |=> !failSafe);

  // R8: fail-safe holds until re-initialise
  p_hold_fs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (failSafe && !reinit) |=> failSafe);

  // R9: re-initialise leaves fail-safe
  p_reinit_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    reinit |=> !failSafe);

endmodule

// File: rtl/wd_failsafe.sv
module wd_failsafe
  import wd_failsafe_pkg::*;
#(
  parameter int BASE_TICKS = 64,
  parameter int DIV_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wakeIn,
  input  logic             wdIn,
  input  logic [DIV_W-1:0] divSel,
  input  logic             wdBit,
  input  logic             reinit,
  output logic             failSafe,
  output logic             forceHs0,
  output logic             forceHs2
);
  wdStrobes_t strb;
  logic       atLast;

  wd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wakeIn(wakeIn), .wdIn(wdIn),
    .wdBit(wdBit), .reinit(reinit), .atLast(atLast), .strb(strb),
    .failSafe(failSafe)
  );

  wd_datapath #(.BASE_TICKS(BASE_TICKS), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .divSel(divSel), .atLast(atLast)
  );

  assign forceHs0 = failSafe;
  assign forceHs2 = failSafe;

  // R8: fail-safe is only entered from a completed count with no restart
  p_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failSafe) |-> $past(tick && wakeIn && !reinit));

endmodule

// File: tb/wd_failsafe_tb_top.sv
module wd_failsafe_tb_top;
  localparam int BASE = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0, tick = 1'b1, wakeIn = 1'b1, wdIn = 1'b0, wdBit = 1'b0, reinit = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic failSafe, forceHs0, forceHs2;

  int checks = 0, fails = 0;
  string phase = "R1";

  // reference model state
  int mCnt = 0, mDiv = 0;
  bit mFs = 0, mWdP = 0, mBitP = 0;

  always #2 clk = ~clk;  // 250 MHz

  wd_failsafe #(.BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wakeIn(wakeIn), .wdIn(wdIn),
    .divSel(divSel), .wdBit(wdBit), .reinit(reinit),
    .failSafe(failSafe), .forceHs0(forceHs0), .forceHs2(forceHs2)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mDiv = 0; mFs = 0; mWdP = 0; mBitP = 0;
    end else begin
      bit rs, tg;
      int lim;
      tg  = (wdBit != mBitP);
      rs  = (wdIn != mWdP) || tg || reinit || !wakeIn;
      lim = BASE / (1 << mDiv);
      if (reinit) mFs = 0;
      else if (!rs && tick && !mFs && mCnt == lim - 1) begin
        mFs = 1; mCnt = 0;
      end
      if (rs) mCnt = 0;
      else if (tick && !mFs) mCnt = mCnt + 1;
      if (tg) mDiv = divSel;
      mWdP = wdIn; mBitP = wdBit;
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(phase, failSafe, mFs, "failSafe");
    check(phase, forceHs0, mFs, "forceHs0");
    check(phase, forceHs2, mFs, "forceHs2");
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseReinit();
    @(negedge clk); reinit = 1'b1;
    @(negedge clk); reinit = 1'b0;
  endtask

  initial begin
    int seen;
    fork
      begin
        cyc(100000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none

    // R1: reset state
    cyc(4);
    check("R1", failSafe, 1'b0, "reset failSafe");

    // R3: base period from reset release
    phase = "R3";
    rstN = 1'b1;
    seen = 0;
    for (int i = 1; i <= 200 && seen == 0; i++) begin
      @(negedge clk);
      if (failSafe) seen = i;
    end
    checks++;
    if (seen != BASE) begin
      fails++;
      $display("FAIL R3 trip cycle actual=%0d expected=%0d", seen, BASE);
    end

    // R8: heartbeat activity does not leave fail-safe
    phase = "R8";
    for (int i = 0; i < 6; i++) begin wdIn = ~wdIn; cyc(3); end
    wdBit = ~wdBit; cyc(5);
    check("R8", forceHs2, 1'b1, "held force");

    // R9 then R4: reinit, then regular heartbeat keeps it quiet
    phase = "R9";
    pulseReinit();
    check("R9", failSafe, 1'b0, "after reinit");
    phase = "R4";
    for (int i = 0; i < 6; i++) begin cyc(40); wdIn = ~wdIn; end
    cyc(80);

    // R6: divisor staged without toggle has no effect
    phase = "R6";
    pulseReinit();
    divSel = 2'd2;
    cyc(90);
    pulseReinit();

    // R5 and R7: toggle loads shortest divisor, trip 8 ticks after
    phase = "R5";
    divSel = 2'd3;
    wdBit = ~wdBit;
    seen = 0;
    for (int i = 1; i <= 40 && seen == 0; i++) begin
      @(negedge clk);
      if (failSafe) seen = i;
    end
    checks++;
    if (seen != 9) begin
      fails++;
      $display("FAIL R5 trip cycle actual=%0d expected=%0d", seen, 9);
    end
    phase = "R7";
    pulseReinit();
    divSel = 2'd1;
    cyc(20); wdBit = ~wdBit;
    cyc(20); wdBit = ~wdBit;
    cyc(40);

    // R10: gated ticks
    phase = "R10";
    pulseReinit();
    for (int i = 0; i < 150; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    tick = 1'b1;

    // R2: disarmed
    phase = "R2";
    pulseReinit();
    wakeIn = 1'b0;
    cyc(300);
    check("R2", failSafe, 1'b0, "wake low");
    wakeIn = 1'b1;
    cyc(20);

    // R1: reset mid-run
    phase = "R1";
    rstN = 1'b0;
    cyc(3);
    check("R1", failSafe, 1'b0, "mid reset");
    rstN = 1'b1;
    cyc(70);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule